// File: doc/BRIEF.md
# Run-Recency Pattern Detector

This block watches a single serial bit stream, one bit per clock, and reports which of two competing patterns was completed last: a run of three equal 0 bits or a run of three equal 1 bits. Its output is 1 while the latest completed triple was made of zeros. It is 0 while the latest completed triple was made of ones, and also when no triple has been completed since reset.

The output is a Moore output. It is decoded from registered state only, so a completing input shows up on the output one clock after it is sampled. Internally the block keeps the value and length of the current run of equal bits, saturated at three, together with a one-bit recency flag. A synchronous active-high reset clears the run and the flag, which gives the output a defined value from the start.

Top module: `run_recency_detector`

## Requirements
- R1: While reset is high at a clock edge, and in the cycle that follows that edge, `z_out` is 0. Reset also clears the run tracker, so bits sampled before reset never count toward a triple.
- R2: After three consecutive sampled 0 bits, `z_out` is 1 in the cycle that follows the edge sampling the third 0.
- R3: After three consecutive sampled 1 bits, `z_out` is 0 in the cycle that follows the edge sampling the third 1.
- R4: `z_out` changes only in the cycle right after an edge that completed a triple, or extended one.
- R5: A run longer than three equal bits keeps `z_out` at the value set by its first three bits.
- R6: A bit opposite to the current run starts a new run of length one and leaves `z_out` unchanged. A run of two bits also leaves `z_out` unchanged.
- R7: For the input 1 1 1 0 0 1 0 1 1 1 0 0 1 0 0 0 0 1 1 1 1 0 1 applied after reset, `z_out` is 0 until the edge sampling the third of the 0 0 0 0 run. It is 1 from then until the edge sampling the third bit of the 1 1 1 1 run, and 0 afterwards.
- R8: A reset asserted in the middle of a run discards that run. After reset, three fresh equal bits are needed to set `z_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | 1 | Serial data bit, sampled on each rising edge |
| z_out | output | 1 | 1 when the latest completed triple was zeros |

## Verification
Every result of this block is due in the cycle after the edge that samples the deciding bit, because `z_out` is driven by the single recency register. The bench drives each bit at a falling edge and reads `z_out` at the next falling edge, half a period after the sampling edge. Each check therefore compares the output against a model that has already absorbed exactly that bit. The model rescans the last three bits pushed since reset and rebuilds the expected value on its own.

// File: rtl/rrd_pkg.sv
`timescale 1ns/1ps
package rrd_pkg;

    // Length of a run that counts as a completed pattern.
    localparam int unsigned TRIPLE_LEN = 3;
    localparam int unsigned CNT_W      = $clog2(TRIPLE_LEN + 1);

    typedef logic [CNT_W-1:0] run_cnt_t;

    // The run of equal bits currently being observed.
    typedef struct packed {
        logic     bit_val;
        run_cnt_t length;
    } run_state_t;

    // Which kind of triple was completed last.
    typedef enum logic {
        REC_ONES_OR_NONE = 1'b0,
        REC_ZEROS        = 1'b1
    } recency_e;

    localparam run_cnt_t   RUN_FULL  = run_cnt_t'(TRIPLE_LEN);
    localparam run_state_t RUN_EMPTY = '{bit_val: 1'b0, length: '0};

    // Advance the run by one sampled bit. The length saturates at full.
    function automatic run_state_t run_advance(run_state_t cur, logic x);
        run_state_t nxt;
        if (cur.length == '0 || cur.bit_val != x) begin
            nxt.bit_val = x;
            nxt.length  = run_cnt_t'(1);
        end else if (cur.length == RUN_FULL) begin
            nxt = cur;
        end else begin
            nxt.bit_val = cur.bit_val;
            nxt.length  = cur.length + run_cnt_t'(1);
        end
        return nxt;
    endfunction

    // A triple counts when the next run length is full.
    function automatic logic run_is_full(run_state_t st);
        return st.length == RUN_FULL;
    endfunction

    // Moore output decode.
    function automatic logic recency_to_out(recency_e rec);
        return rec == REC_ZEROS;
    endfunction

endpackage

// File: rtl/rrd_run_tracker.sv
`timescale 1ns/1ps
module rrd_run_tracker
    import rrd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic x_in,
    output logic triple_done,
    output logic triple_bit
);

    run_state_t run_q;
    run_state_t run_d;

    always_comb begin
        run_d       = run_advance(run_q, x_in);
        triple_done = run_is_full(run_d);
        triple_bit  = run_d.bit_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= RUN_EMPTY;
        end else begin
            run_q <= run_d;
        end
    end

endmodule

// File: rtl/rrd_recency_reg.sv
`timescale 1ns/1ps
module rrd_recency_reg
    import rrd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     triple_done,
    input  logic     triple_bit,
    output recency_e recency
);

    recency_e rec_d;

    always_comb begin
        rec_d = recency;
        if (triple_done) begin
            rec_d = triple_bit ? REC_ONES_OR_NONE : REC_ZEROS;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            recency <= REC_ONES_OR_NONE;
        end else begin
            recency <= rec_d;
        end
    end

endmodule

// File: rtl/run_recency_detector.sv
`timescale 1ns/1ps
module run_recency_detector
    import rrd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic x_in,
    output logic z_out
);

    logic     triple_done;
    logic     triple_bit;
    recency_e recency;

    rrd_run_tracker u_tracker (
        .clk         (clk),
        .rst         (rst),
        .x_in        (x_in),
        .triple_done (triple_done),
        .triple_bit  (triple_bit)
    );

    rrd_recency_reg u_recency (
        .clk         (clk),
        .rst         (rst),
        .triple_done (triple_done),
        .triple_bit  (triple_bit),
        .recency     (recency)
    );

    assign z_out = recency_to_out(recency);

endmodule

// File: rtl/rrd_checker.sv
`timescale 1ns/1ps
module rrd_checker (
    input logic clk,
    input logic rst,
    input logic x_in,
    input logic z_out
);

    // Independent run counters of sampled zeros and ones, saturating at 3.
    logic [1:0] zrun;
    logic [1:0] orun;

    always_ff @(posedge clk) begin
        if (rst) begin
            zrun <= 2'd0;
            orun <= 2'd0;
        end else if (x_in) begin
            orun <= (orun == 2'd3) ? 2'd3 : orun + 2'd1;
            zrun <= 2'd0;
        end else begin
            zrun <= (zrun == 2'd3) ? 2'd3 : zrun + 2'd1;
            orun <= 2'd0;
        end
    end

    // R1
    p_reset_clears_r1: assert property (@(posedge clk) rst |=> !z_out);

    // R2
    p_zero_triple_r2: assert property (@(posedge clk) disable iff (rst)
        (zrun == 2'd3) |-> z_out);

    // R3
    p_one_triple_r3: assert property (@(posedge clk) disable iff (rst)
        (orun == 2'd3) |-> !z_out);

    // R4
    p_change_on_triple_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(z_out)) |-> (zrun == 2'd3 || orun == 2'd3));

    // R5
    p_long_run_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (zrun == 2'd3 || orun == 2'd3)
         && ($past(zrun) == 2'd3 || $past(orun) == 2'd3)) |-> $stable(z_out));

    // R6
    p_short_run_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && zrun != 2'd3 && orun != 2'd3) |-> $stable(z_out));

endmodule

bind run_recency_detector rrd_checker chk_i (
    .clk   (clk),
    .rst   (rst),
    .x_in  (x_in),
    .z_out (z_out)
);

// File: tb/run_recency_detector_tb_top.sv
`timescale 1ns/1ps
module run_recency_detector_tb_top;

    localparam real HALF_NS = 4.0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x_in = 1'b0;
    logic z_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model: last three bits pushed since reset.
    logic [2:0] hist;
    int         hist_n;
    logic       ref_z;

    always #(HALF_NS) clk = ~clk;

    run_recency_detector dut_i (
        .clk   (clk),
        .rst   (rst),
        .x_in  (x_in),
        .z_out (z_out)
    );

    task automatic check(string tag, logic exp);
        checks++;
        if (z_out !== exp) begin
            errors++;
            $display("FAIL %s: z_out=%b expected=%b at %0t", tag, z_out, exp, $time);
        end
    endtask

    task automatic model_clear();
        hist   = 3'b000;
        hist_n = 0;
        ref_z  = 1'b0;
    endtask

    task automatic model_push(logic b);
        hist = {hist[1:0], b};
        if (hist_n < 3) hist_n++;
        if (hist_n == 3 && hist == 3'b000) ref_z = 1'b1;
        if (hist_n == 3 && hist == 3'b111) ref_z = 1'b0;
    endtask

    // Drive a bit at a falling edge, read the result at the next falling edge.
    task automatic push(logic b, string tag);
        x_in = b;
        model_push(b);
        @(posedge clk);
        @(negedge clk);
        check(tag, ref_z);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R1 during reset", 1'b0);
        rst = 1'b0;
        model_clear();
    endtask

    task automatic t_reset_state();
        do_reset();
        @(posedge clk);
        @(negedge clk);
        check("R1 after reset", 1'b0);
    endtask

    task automatic t_zero_triple();
        do_reset();
        push(1'b0, "R2 first zero");
        push(1'b0, "R2 second zero");
        push(1'b0, "R2 third zero");
        check("R2 z set", 1'b1);
    endtask

    task automatic t_one_triple();
        push(1'b1, "R3 first one");
        push(1'b1, "R3 second one");
        push(1'b1, "R3 third one");
        check("R3 z cleared", 1'b0);
    endtask

    task automatic t_long_runs();
        do_reset();
        for (int i = 0; i < 6; i++) push(1'b0, "R5 long zero run");
        check("R5 z held high", 1'b1);
        for (int i = 0; i < 5; i++) push(1'b1, "R5 long one run");
        check("R5 z held low", 1'b0);
    endtask

    task automatic t_interruptions();
        do_reset();
        push(1'b0, "R6 setup");
        push(1'b0, "R6 setup");
        push(1'b0, "R6 setup");
        push(1'b1, "R6 single one");
        check("R6 z unchanged after single one", 1'b1);
        push(1'b0, "R6 new zero run");
        push(1'b0, "R6 two zeros");
        push(1'b1, "R6 one");
        push(1'b1, "R6 two ones");
        check("R6 z unchanged after two ones", 1'b1);
        push(1'b1, "R4 third one flips");
        check("R4 flip due after third one", 1'b0);
    endtask

    task automatic t_sample_trace();
        logic [22:0] seq = 23'b11100101110010000111101;
        do_reset();
        for (int i = 22; i >= 0; i--) push(seq[i], "R7 sample trace");
        check("R7 trace ends low", 1'b0);
    endtask

    task automatic t_mid_reset();
        do_reset();
        push(1'b0, "R8 pre-reset zero");
        push(1'b0, "R8 pre-reset zero");
        do_reset();
        push(1'b0, "R8 fresh zero one");
        check("R8 old run discarded", 1'b0);
        push(1'b0, "R8 fresh zero two");
        push(1'b0, "R8 fresh zero three");
        check("R8 fresh triple sets z", 1'b1);
    endtask

    initial begin
        model_clear();
        t_reset_state();
        t_zero_triple();
        t_one_triple();
        t_long_runs();
        t_interruptions();
        t_sample_trace();
        t_mid_reset();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(HALF_NS * 2.0 * 200000.0);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule